// File: doc/BRIEF.md
# Three-Channel Match-Compare Timer

This block holds a set of independent up-counters, each watched by several match comparators, behind a small word-addressed register bus. Software starts and stops each counter through one shared run register and loads the match values. It chooses per counter between a reload mode and a free-running mode, and it masks or clears the per-comparator event flags. A combined interrupt line is raised while any unmasked flag is set.

The live count is never read directly. Software writes to a counter's capture register, waits a fixed number of clock cycles, and then reads the captured value back from the same address. In reload mode, comparator 0 sets the period: a match value of N gives an interval of N+1 counts. The smallest interval in use is 16 counts (match 15) and the largest is 0xFFFFFFFE (match 0xFFFFFFFD).

Addresses are byte addresses and must be word aligned; bits [1:0] must be zero. Bits [7:5] select a block: 0 is the global block and t+1 is counter t. Bits [4:2] select the word inside the block: 0 = mode, 1 = flags, 2 = mask, 3 = capture, and 4+c = match value of comparator c. In the global block, word 0 is the run register.

Top module: `mct_timer_unit`

## Requirements
- R1: After reset the run register, every flag register, every capture register and the interrupt output read as zero.
- R2: Bit t of the run register (address 0x00) runs counter t. Writing a 1 to a bit that was 0 restarts that counter from zero. A running counter advances by one every clock cycle, and the counters do not affect each other.
- R3: Clearing a counter's run bit freezes its count at the value it reached on the clock edge of that write.
- R4: Flag bit c (flags word, bit c) sets on the clock edge after a running counter equals match value c, so match N flags after N+1 counts. It stays set until software clears it.
- R5: Writing the flags word clears exactly the bits written as 1, so 0x2 clears only comparator 1 and 0x7 clears all three.
- R6: The interrupt output is high exactly when some flag bit is set together with its mask bit (mask word, bit c).
- R7: With mode bit 0 set (reload mode), a counter that equals match value 0 returns to zero on the next edge, giving a period of match0+1.
- R8: With mode bit 0 clear (free-running mode), a counter keeps advancing past every match value and wraps only at full scale.
- R9: A write to the capture word samples the count as it was at that write's clock edge. The new value appears on reads SNAP_DLY (default 4) cycles later, and earlier reads return the previous capture.
- R10: Match registers hold all 32 bits and read back exactly as written, including 0xFFFFFFFD and 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, combinational from the address |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The assertions assume that each bus write is a single-cycle strobe, that software does not request a new capture while one is still pending, and that at most NUM_CMP comparators are addressed. The bench issues one write per cycle with gaps between writes, and it waits out the full capture delay before the next capture request. Random runs keep the reload match between 16 and 115, so the captured counts stay small and the expected values can be computed exactly from the cycle numbers of the start and capture writes.

// File: rtl/mct_pkg.sv
package mct_pkg;
  localparam logic [2:0] OFF_MODE   = 3'd0;
  localparam logic [2:0] OFF_FLAGS  = 3'd1;
  localparam logic [2:0] OFF_MASK   = 3'd2;
  localparam logic [2:0] OFF_CAPT   = 3'd3;
  localparam logic [2:0] OFF_MATCH0 = 3'd4;
  localparam logic [2:0] OFF_RUN    = 3'd0;
endpackage

// File: rtl/mct_regif.sv
module mct_regif
  import mct_pkg::*;
#(
  parameter int NT = 3,
  parameter int NC = 3,
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_sel,
  input  logic                           bus_wr,
  input  logic [AW-1:0]                  bus_addr,
  input  logic [W-1:0]                   bus_wdata,
  output logic [W-1:0]                   bus_rdata,
  output logic [NT-1:0]                  run_o,
  output logic [NT-1:0]                  start_o,
  output logic [NT-1:0]                  periodic_o,
  output logic [NT-1:0][NC-1:0]          mask_o,
  output logic [NT-1:0][NC-1:0][W-1:0]   match_o,
  output logic [NT-1:0][NC-1:0]          clr_o,
  output logic [NT-1:0]                  capt_o,
  input  logic [NT-1:0][NC-1:0]          flags_i,
  input  logic [NT-1:0][W-1:0]           capt_i
);
  localparam int BW = AW - 5;

  logic [BW-1:0] blk;
  logic [2:0]    off;
  logic          aligned;
  logic          wr_en;
  logic          glob_hit;
  logic [NT-1:0] tmr_hit;

  logic [NT-1:0]                run_q, run_d;
  logic [NT-1:0]                per_q, per_d;
  logic [NT-1:0][NC-1:0]        msk_q, msk_d;
  logic [NT-1:0][NC-1:0][W-1:0] mat_q, mat_d;

  assign blk      = bus_addr[AW-1:5];
  assign off      = bus_addr[4:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign wr_en    = bus_sel & bus_wr & aligned;
  assign glob_hit = (blk == '0);

  for (genvar t = 0; t < NT; t++) begin : g_hit
    assign tmr_hit[t] = (blk == BW'(t + 1));
  end

  always_comb begin
    run_d = run_q;
    per_d = per_q;
    msk_d = msk_q;
    mat_d = mat_q;
    if (wr_en && glob_hit && off == OFF_RUN) run_d = bus_wdata[NT-1:0];
    for (int t = 0; t < NT; t++) begin
      if (wr_en && tmr_hit[t]) begin
        if (off == OFF_MODE) per_d[t] = bus_wdata[0];
        if (off == OFF_MASK) msk_d[t] = bus_wdata[NC-1:0];
        for (int c = 0; c < NC; c++) begin
          if (off == OFF_MATCH0 + 3'(c)) mat_d[t][c] = bus_wdata;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      per_q <= '0;
      msk_q <= '0;
      mat_q <= '0;
    end else begin
      run_q <= run_d;
      per_q <= per_d;
      msk_q <= msk_d;
      mat_q <= mat_d;
    end
  end

  always_comb begin
    for (int t = 0; t < NT; t++) begin
      start_o[t] = wr_en && glob_hit && off == OFF_RUN && bus_wdata[t] && !run_q[t];
      clr_o[t]   = (wr_en && tmr_hit[t] && off == OFF_FLAGS) ? bus_wdata[NC-1:0] : '0;
      capt_o[t]  = wr_en && tmr_hit[t] && off == OFF_CAPT;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (glob_hit && off == OFF_RUN) bus_rdata[NT-1:0] = run_q;
    for (int t = 0; t < NT; t++) begin
      if (tmr_hit[t]) begin
        if (off == OFF_MODE)  bus_rdata[0]    = per_q[t];
        if (off == OFF_FLAGS) bus_rdata[NC-1:0] = flags_i[t];
        if (off == OFF_MASK)  bus_rdata[NC-1:0] = msk_q[t];
        if (off == OFF_CAPT)  bus_rdata = capt_i[t];
        for (int c = 0; c < NC; c++) begin
          if (off == OFF_MATCH0 + 3'(c)) bus_rdata = mat_q[t][c];
        end
      end
    end
  end

  assign run_o      = run_q;
  assign periodic_o = per_q;
  assign mask_o     = msk_q;
  assign match_o    = mat_q;

  // R10: a match write lands unmodified in the register
  a_r10_match_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tmr_hit[0] && off == OFF_MATCH0) |=> (mat_q[0][0] == $past(bus_wdata)));

  // R2: a start pulse is seen only for a counter that was stopped and is now running
  a_r2_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    start_o[0] |=> run_q[0]);
endmodule

// File: rtl/mct_counter.sv
module mct_counter #(
  parameter int NC = 3,
  parameter int W  = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run_i,
  input  logic                   start_i,
  input  logic                   periodic_i,
  input  logic [NC-1:0][W-1:0]   match_i,
  input  logic [NC-1:0]          clr_i,
  output logic [W-1:0]           cnt_o,
  output logic [NC-1:0]          flags_o
);
  logic [W-1:0]  cnt_q, cnt_d;
  logic [NC-1:0] flg_q, flg_d;
  logic [NC-1:0] hit;
  logic          cnt_en;

  for (genvar c = 0; c < NC; c++) begin : g_cmp
    assign hit[c] = run_i && (cnt_q == match_i[c]);
  end

  assign cnt_en = start_i | run_i;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)                   cnt_d = '0;
    else if (periodic_i && hit[0]) cnt_d = '0;
    else                           cnt_d = cnt_q + W'(1);
  end

  always_comb begin
    flg_d = (flg_q & ~clr_i) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      flg_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      flg_q <= flg_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign flags_o = flg_q;

  // R2: a running counter advances by one when nothing restarts or reloads it
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !start_i && !(periodic_i && cnt_q == match_i[0])) |=> (cnt_q == $past(cnt_q) + W'(1)));

  // R3: a stopped counter holds its value
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !start_i) |=> $stable(cnt_q));

  // R7: reload mode wraps to zero after matching comparator 0
  a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !start_i && periodic_i && cnt_q == match_i[0]) |=> (cnt_q == '0));

  // R8: free-running mode steps over a match instead of reloading
  a_r8_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !start_i && !periodic_i) |=> (cnt_q == $past(cnt_q) + W'(1)));

  for (genvar c = 0; c < NC; c++) begin : g_chk
    // R4: an equal compare on a running counter raises the flag on the next edge
    a_r4_set: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && cnt_q == match_i[c]) |=> flg_q[c]);
    // R4/R5: a flag drops only by a write-one-to-clear
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flg_q[c] && !clr_i[c]) |=> flg_q[c]);
  end
endmodule

// File: rtl/mct_capture.sv
module mct_capture #(
  parameter int W   = 32,
  parameter int DLY = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] capt_o
);
  localparam int DW = $clog2(DLY + 1);

  logic [W-1:0]  pend_q, pend_d;
  logic [W-1:0]  capt_q, capt_d;
  logic [DW-1:0] wait_q, wait_d;
  logic          publish;

  assign publish = !req_i && (wait_q == DW'(1));

  always_comb begin
    pend_d = pend_q;
    wait_d = wait_q;
    capt_d = capt_q;
    if (req_i) begin
      pend_d = cnt_i;
      wait_d = DW'(DLY);
    end else if (wait_q != '0) begin
      wait_d = wait_q - DW'(1);
    end
    if (publish) capt_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      wait_q <= '0;
      capt_q <= '0;
    end else begin
      pend_q <= pend_d;
      wait_q <= wait_d;
      capt_q <= capt_d;
    end
  end

  assign capt_o = capt_q;

  // R9: the visible capture changes only when the delay expires
  a_r9_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !publish |=> $stable(capt_q));

  // R9: a request samples the live count of its own edge
  a_r9_sample: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> (pend_q == $past(cnt_i)));
endmodule

// File: rtl/mct_timer_unit.sv
module mct_timer_unit #(
  parameter int NUM_TMR  = 3,
  parameter int NUM_CMP  = 3,
  parameter int CNT_W    = 32,
  parameter int ADDR_W   = 8,
  parameter int SNAP_DLY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq_o
);
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  logic [NUM_TMR-1:0]                            run, start, periodic, capt_req;
  logic [NUM_TMR-1:0][NUM_CMP-1:0]               mask, clr, flags;
  logic [NUM_TMR-1:0][NUM_CMP-1:0][CNT_W-1:0]    match;
  logic [NUM_TMR-1:0][CNT_W-1:0]                 cnt, capt;

  mct_regif #(.NT(NUM_TMR), .NC(NUM_CMP), .W(CNT_W), .AW(ADDR_W)) regif_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .run_o      (run),
    .start_o    (start),
    .periodic_o (periodic),
    .mask_o     (mask),
    .match_o    (match),
    .clr_o      (clr),
    .capt_o     (capt_req),
    .flags_i    (flags),
    .capt_i     (capt)
  );

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    mct_counter #(.NC(NUM_CMP), .W(CNT_W)) cnt_i (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .run_i      (run[t]),
      .start_i    (start[t]),
      .periodic_i (periodic[t]),
      .match_i    (match[t]),
      .clr_i      (clr[t]),
      .cnt_o      (cnt[t]),
      .flags_o    (flags[t])
    );
    mct_capture #(.W(CNT_W), .DLY(SNAP_DLY)) cap_i (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .req_i  (capt_req[t]),
      .cnt_i  (cnt[t]),
      .capt_o (capt[t])
    );
  end

  assign irq_o = |(flags & mask);

  // R6: with every mask bit clear the line stays low
  a_r6_masked: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mask == '0) |-> !irq_o);

  // R6: the line cannot be high while no flag is set
  a_r6_needs_flag: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_o |-> (flags != '0));

  // R1: right after reset release nothing is flagged
  a_r1_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> (flags == '0 && !irq_o));
endmodule

// File: tb/mct_timer_unit_tb_top.sv
`timescale 1ns/1ps
module mct_timer_unit_tb_top;
  localparam int NT = 3;
  localparam int NC = 3;
  localparam int DLY = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq_o;

  int unsigned cyc = 0;
  int          errors = 0;
  int          checks = 0;
  logic [NT-1:0] en_sh = '0;
  int unsigned   e0 [NT];
  logic [31:0]   last_capt [NT];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mct_timer_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  function automatic logic [7:0] ra(input int t, input int off);
    return 8'(((t + 1) << 5) | (off << 2));
  endfunction

  function automatic logic [31:0] exp_cnt(input int unsigned n, input bit per, input int unsigned m);
    return per ? 32'(n % (m + 1)) : 32'(n);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic start_tmr(input int t);
    en_sh[t] = 1'b0;
    wr(8'h00, 32'(en_sh));
    en_sh[t] = 1'b1;
    wr(8'h00, 32'(en_sh));
    e0[t] = cyc;
  endtask

  task automatic stop_tmr(input int t, output int unsigned es);
    en_sh[t] = 1'b0;
    wr(8'h00, 32'(en_sh));
    es = cyc;
  endtask

  // capture request; the early read must still show the previous value (R9)
  task automatic capture(input int t, output logic [31:0] v, output int unsigned ew);
    logic [31:0] early;
    wr(ra(t, 3), 32'h0);
    ew = cyc;
    rd(ra(t, 3), early);
    chk("R9 early read keeps old capture", early, last_capt[t]);
    repeat (DLY) @(negedge clk);
    rd(ra(t, 3), v);
    last_capt[t] = v;
  endtask

  task automatic wait_until(input int unsigned c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int unsigned ew, es, held, m;
    void'($urandom(32'd4242));
    for (int t = 0; t < NT; t++) last_capt[t] = '0;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(8'h00, v);    chk("R1 run register", v, 32'h0);
    rd(ra(0, 1), v); chk("R1 flags t0", v, 32'h0);
    rd(ra(2, 3), v); chk("R1 capture t2", v, 32'h0);
    chk("R1 irq", 32'(irq_o), 32'h0);

    // R10 match readback at the limits
    wr(ra(2, 5), 32'hFFFF_FFFD); rd(ra(2, 5), v); chk("R10 max match", v, 32'hFFFF_FFFD);
    wr(ra(2, 4), 32'h0000_000F); rd(ra(2, 4), v); chk("R10 min match", v, 32'h0000_000F);

    // R4/R7 minimum interval: reload mode, match 15
    wr(ra(0, 0), 32'h1);
    wr(ra(0, 4), 32'd15);
    start_tmr(0);
    wait_until(e0[0] + 15);
    rd(ra(0, 1), v); chk("R4 no flag before interval", v & 32'h1, 32'h0);
    @(negedge clk);
    rd(ra(0, 1), v); chk("R4 flag at interval of 16", v & 32'h1, 32'h1);
    wait_until(e0[0] + 40);
    capture(0, v, ew);
    chk("R7 reload count", v, exp_cnt(ew - 1 - e0[0], 1'b1, 15));

    // R3 stop freezes count
    stop_tmr(0, es);
    held = (es - e0[0]) % 16;
    capture(0, v, ew);
    chk("R3 held count", v, 32'(held));

    // R8 free-running timer 1, R2 independence
    wr(ra(1, 0), 32'h0);
    wr(ra(1, 4), 32'd20);
    start_tmr(1);
    wait_until(e0[1] + 45);
    capture(1, v, ew);
    chk("R8 free count past match", v, exp_cnt(ew - 1 - e0[1], 1'b0, 20));
    rd(ra(1, 1), v); chk("R4 flag free mode", v & 32'h1, 32'h1);
    capture(0, v2, ew);
    chk("R2 stopped timer unaffected", v2, 32'(held));
    rd(8'h00, v); chk("R2 run register", v, 32'h2);

    // R5 write-one-to-clear on timer 2
    wr(ra(2, 0), 32'h0);
    wr(ra(2, 4), 32'd15); wr(ra(2, 5), 32'd17); wr(ra(2, 6), 32'd19);
    start_tmr(2);
    wait_until(e0[2] + 25);
    rd(ra(2, 1), v); chk("R5 all flags set", v, 32'h7);
    wr(ra(2, 1), 32'h2); rd(ra(2, 1), v); chk("R5 clear only bit 1", v, 32'h5);
    wr(ra(2, 1), 32'h5); rd(ra(2, 1), v); chk("R5 clear rest", v, 32'h0);

    // R2/R7 random reload runs
    for (int i = 0; i < 20; i++) begin
      int t;
      int unsigned run_len;
      t = int'($urandom % NT);
      m = 16 + ($urandom % 100);
      run_len = 5 + ($urandom % 300);
      stop_tmr(t, es);
      wr(ra(t, 0), 32'h1);
      wr(ra(t, 4), 32'(m));
      start_tmr(t);
      wait_until(e0[t] + run_len);
      capture(t, v, ew);
      chk("R7 random reload count", v, exp_cnt(ew - 1 - e0[t], 1'b1, m));
    end

    // R6 masking
    en_sh = '0;
    wr(8'h00, 32'h0);
    for (int t = 0; t < NT; t++) wr(ra(t, 1), 32'h7);
    chk("R6 irq low after clear", 32'(irq_o), 32'h0);
    wr(ra(0, 2), 32'h1);
    chk("R6 mask alone no irq", 32'(irq_o), 32'h0);
    wr(ra(0, 0), 32'h1);
    wr(ra(0, 4), 32'd15);
    start_tmr(0);
    wait_until(e0[0] + 20);
    stop_tmr(0, es);
    chk("R6 irq high", 32'(irq_o), 32'h1);
    wr(ra(0, 2), 32'h0);
    chk("R6 irq masked", 32'(irq_o), 32'h0);
    wr(ra(0, 2), 32'h1);
    chk("R6 irq unmasked", 32'(irq_o), 32'h1);
    wr(ra(0, 1), 32'h1);
    chk("R6 irq after clear", 32'(irq_o), 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule